// File: doc/BRIEF.md
# Live-Insertion Board Sequencer

This block is the board-side controller for a card that can be plugged into or pulled out of a powered backplane. It takes the ejector handle switch, the backplane power-permit line (active low), a power-good monitor, the sampled bus-grant and interrupt-acknowledge daisy-chain lines, a front-panel toggle and host commands. From these it orders every step of insertion and extraction: it switches board power, holds logic reset, enables the bus transceivers, and hands daisy-chain ownership between the backplane bypass switch and the board's own grant/acknowledge pass-through. It also drives the removal interrupt and the blue, red and green indicators.

The handle and power-good inputs are synchronised and debounced before the state machine uses them. Ownership of the daisy chain is claimed or given back only while every grant line and the acknowledge line are idle. The board pass-through is never on while the backplane bypass is enabled, which happens whenever the ownership output is released. The state machine has eight states: IDLE (0), WAIT_PERMIT (1), POWER_UP (2), LOADING (3), RUN (4), QUIESCE (5), OFF_BUS (6) and HOST_RESET (7). Transitions: IDLE→WAIT_PERMIT on handle seated; WAIT_PERMIT→IDLE on handle open; WAIT_PERMIT→POWER_UP on permit low; POWER_UP→LOADING on power good; LOADING→RUN on host enable with idle chains; LOADING→HOST_RESET on host reset; RUN→QUIESCE on any removal notice or host reset; QUIESCE→OFF_BUS (or →HOST_RESET for a pending host reset) on idle chains; POWER_UP/LOADING/HOST_RESET→OFF_BUS on a removal notice; OFF_BUS→IDLE or →WAIT_PERMIT on permit high or handle open; any powered state after POWER_UP→IDLE on power-good loss.

Top module: `li_board_seq`

## Requirements
- R1: After reset the state output is 0 (IDLE), power, transceiver, pass-through, bus-request/interrupt enables and the ownership drive are all 0, logic reset is 1, and the red and blue indicators are lit with green dark.
- R2: With the handle seated (handle input 1 after debounce) and the permit line high, the state is 1, board power stays off and the blue indicator is lit.
- R3: When the permit line goes low in state 1, the next state is 2 with power enabled, logic reset held, pass-through and bus-request/interrupt enables off, and red and green both lit.
- R4: On debounced power good in state 2 the block enters state 3: logic reset released, transceivers on, pass-through, bus-request/interrupt and ownership drive all off, red and green both lit.
- R5: Leaving state 3 for state 4 needs both host enable and all grant lines and the acknowledge line high (inactive); in state 4 the ownership drive, pass-through and bus-request/interrupt enables are 1, blue is off, green on, red off.
- R6: The ownership drive changes only in a cycle following one where all grant and acknowledge lines were inactive, except that it is released after a power-good loss.
- R7: The pass-through enable is never 1 while the ownership drive is 0 (the backplane bypass is then enabled), and bus-request/interrupt enable is never 1 without the transceivers.
- R8: A removal notice in state 4 moves to state 5, which keeps ownership and pass-through until the chains are idle; then state 6 turns off pass-through, bus-request/interrupt, transceivers and ownership with power still on; then permit high or handle open removes power and lights blue.
- R9: The removal interrupt is 1 during an extraction started by the handle opening or the toggle switch, and stays 0 for one started by the host power-off command.
- R10: Power-good loss in any state from 3 onward, or in state 6 or 7, returns the block to state 0 at the next clock, releasing ownership and power.
- R11: A host reset command ends in state 7: power on, logic reset held, transceivers, pass-through and ownership off, red lit and green dark; the state is held until a removal notice or power-good loss.
- R12: In state 4 the watchdog-fault input lights the red indicator alongside green.
- R13: A handle change shorter than the debounce window has no effect on the state.
- R14: The state output uses the encoding listed above (IDLE=0 through HOST_RESET=7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| handle_raw | input | 1 | Handle switch, 1 = seated (raw) |
| pwr_good_raw | input | 1 | Board power-good monitor (raw) |
| permit_n | input | 1 | Backplane power-permit line, low = allowed |
| bg_n | input | N_GRANT | Sampled bus-grant chain lines, active low |
| iack_n | input | 1 | Sampled acknowledge chain line, active low |
| host_enable | input | 1 | Host permits handover to normal operation |
| host_poweroff | input | 1 | Host removal notice |
| host_reset | input | 1 | Host command for latched board reset |
| toggle_off | input | 1 | Front-panel toggle requesting power-off |
| wdog_fault | input | 1 | On-board watchdog anomaly |
| pwr_en | output | 1 | Power switch enable |
| logic_rst | output | 1 | Board logic reset |
| xcvr_en | output | 1 | Bus transceiver enable |
| chain_pass_en | output | 1 | Board grant/acknowledge in-to-out path enable |
| breq_int_en | output | 1 | Bus request and interrupt driver enable |
| own_drive | output | 1 | 1 = drive ownership line low, 0 = released (open) |
| rm_irq | output | 1 | Removal interrupt request |
| led_blue | output | 1 | Blue indicator (safe-to-handle) |
| led_red | output | 1 | Red indicator |
| led_green | output | 1 | Green indicator |
| state_dbg | output | 3 | Current state code |

## Verification
The assertions watch, on every cycle, the exclusion between pass-through and the released ownership line, the rule that ownership only changes after idle chains (or power loss), that power only rises after permit low, that power loss in a powered state drops power the next cycle, and that the host-reset state is held. Only the bench scenarios can show the whole orderings: that handover waits for host enable and each busy grant or acknowledge line, that extraction passes through each step with the right outputs, which removal sources raise the interrupt, the indicator patterns, and that a short handle glitch is ignored.

// File: rtl/li_seq_pkg.sv
package li_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_PRM = 3'd1,
        ST_PWR_UP   = 3'd2,
        ST_LOADING  = 3'd3,
        ST_RUN      = 3'd4,
        ST_QUIESCE  = 3'd5,
        ST_OFF_BUS  = 3'd6,
        ST_HOST_RST = 3'd7
    } seq_state_t;
endpackage

// File: rtl/li_debounce.sv
module li_debounce #(
    parameter int DB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(DB_CYCLES + 1);

    logic        meta_q, sync_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            cnt_q  <= '0;
            clean  <= 1'b0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            if (sync_q == clean) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(DB_CYCLES - 1)) begin
                cnt_q <= '0;
                clean <= sync_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R13: the clean output only takes the synchronised level
    a_r13_follow_sync: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clean) |-> clean == $past(sync_q));
endmodule

// File: rtl/li_seq_fsm.sv
module li_seq_fsm
    import li_seq_pkg::*;
#(
    parameter int N_GRANT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               handle_ok,
    input  logic               pg_ok,
    input  logic               permit_n,
    input  logic [N_GRANT-1:0] bg_n,
    input  logic               iack_n,
    input  logic               host_enable,
    input  logic               host_poweroff,
    input  logic               host_reset,
    input  logic               toggle_off,
    input  logic               wdog_fault,
    output logic               pwr_en,
    output logic               logic_rst,
    output logic               xcvr_en,
    output logic               chain_pass_en,
    output logic               breq_int_en,
    output logic               own_drive,
    output logic               rm_irq,
    output logic               led_blue,
    output logic               led_red,
    output logic               led_green,
    output logic [2:0]         state_dbg
);
    seq_state_t state_q, state_d;
    logic rm_flag_q, hrst_pend_q;
    logic set_rm, set_hrst;
    logic bus_idle, removal, user_rm, powered;

    assign bus_idle = (&bg_n) & iack_n;
    assign user_rm  = !handle_ok | toggle_off;
    assign removal  = user_rm | host_poweroff;
    assign powered  = (state_q != ST_IDLE) && (state_q != ST_WAIT_PRM) &&
                      (state_q != ST_PWR_UP);

    always_comb begin
        state_d  = state_q;
        set_rm   = 1'b0;
        set_hrst = 1'b0;
        unique case (state_q)
            ST_IDLE:     if (handle_ok) state_d = ST_WAIT_PRM;
            ST_WAIT_PRM: begin
                if (!handle_ok)     state_d = ST_IDLE;
                else if (!permit_n) state_d = ST_PWR_UP;
            end
            ST_PWR_UP: begin
                if (removal) begin
                    state_d = ST_OFF_BUS;
                    set_rm  = user_rm;
                end else if (pg_ok) begin
                    state_d = ST_LOADING;
                end
            end
            ST_LOADING: begin
                if (removal) begin
                    state_d = ST_OFF_BUS;
                    set_rm  = user_rm;
                end else if (host_reset) begin
                    state_d = ST_HOST_RST;
                end else if (host_enable && bus_idle) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (removal) begin
                    state_d = ST_QUIESCE;
                    set_rm  = user_rm;
                end else if (host_reset) begin
                    state_d  = ST_QUIESCE;
                    set_hrst = 1'b1;
                end
            end
            ST_QUIESCE: begin
                set_rm = user_rm;
                if (bus_idle)
                    state_d = (hrst_pend_q && !removal) ? ST_HOST_RST : ST_OFF_BUS;
            end
            ST_OFF_BUS: begin
                if (!handle_ok || permit_n)
                    state_d = handle_ok ? ST_WAIT_PRM : ST_IDLE;
            end
            ST_HOST_RST: begin
                if (removal) begin
                    state_d = ST_OFF_BUS;
                    set_rm  = user_rm;
                end
            end
        endcase
        if (powered && !pg_ok) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            rm_flag_q   <= 1'b0;
            hrst_pend_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            rm_flag_q   <= (state_d == ST_QUIESCE || state_d == ST_OFF_BUS) ?
                           (rm_flag_q | set_rm) : 1'b0;
            hrst_pend_q <= (state_d == ST_QUIESCE) ?
                           ((hrst_pend_q & !removal) | set_hrst) : 1'b0;
        end
    end

    always_comb begin
        pwr_en        = 1'b1;
        logic_rst     = 1'b0;
        xcvr_en       = 1'b0;
        chain_pass_en = 1'b0;
        breq_int_en   = 1'b0;
        own_drive     = 1'b0;
        led_blue      = 1'b0;
        led_red       = 1'b0;
        led_green     = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_WAIT_PRM: begin
                pwr_en    = 1'b0;
                logic_rst = 1'b1;
                led_blue  = 1'b1;
                led_red   = 1'b1;
            end
            ST_PWR_UP: begin
                logic_rst = 1'b1;
                led_blue  = 1'b1;
                led_red   = 1'b1;
                led_green = 1'b1;
            end
            ST_LOADING: begin
                xcvr_en   = 1'b1;
                led_blue  = 1'b1;
                led_red   = 1'b1;
                led_green = 1'b1;
            end
            ST_RUN, ST_QUIESCE: begin
                xcvr_en       = 1'b1;
                chain_pass_en = 1'b1;
                breq_int_en   = 1'b1;
                own_drive     = 1'b1;
                led_green     = 1'b1;
                led_red       = (state_q == ST_RUN) && wdog_fault;
            end
            ST_OFF_BUS: begin
                logic_rst = 1'b1;
            end
            ST_HOST_RST: begin
                logic_rst = 1'b1;
                led_red   = 1'b1;
            end
        endcase
    end

    assign rm_irq    = rm_flag_q;
    assign state_dbg = state_q;

    // R7: board pass-through never coexists with the backplane bypass
    a_r7_pass_excl: assert property (@(posedge clk) disable iff (!rst_n)
        chain_pass_en |-> own_drive);
    a_r7_breq_xcvr: assert property (@(posedge clk) disable iff (!rst_n)
        breq_int_en |-> xcvr_en);
    // R6: ownership claimed only after idle chains
    a_r6_own_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(own_drive) |-> $past(bus_idle));
    a_r6_own_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(own_drive) |-> ($past(bus_idle) || !$past(pg_ok)));
    // R2: power only rises after the permit line went low
    a_r2_permit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en) |-> !$past(permit_n));
    // R10: power-good loss in a powered state drops power next cycle
    a_r10_pg_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (powered && !pg_ok) |=> (!pwr_en && !own_drive));
    // R11: host reset state is latched
    a_r11_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOST_RST && pg_ok && !removal) |=> state_q == ST_HOST_RST);
endmodule

// File: rtl/li_board_seq.sv
module li_board_seq #(
    parameter int N_GRANT   = 4,
    parameter int DB_CYCLES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               handle_raw,
    input  logic               pwr_good_raw,
    input  logic               permit_n,
    input  logic [N_GRANT-1:0] bg_n,
    input  logic               iack_n,
    input  logic               host_enable,
    input  logic               host_poweroff,
    input  logic               host_reset,
    input  logic               toggle_off,
    input  logic               wdog_fault,
    output logic               pwr_en,
    output logic               logic_rst,
    output logic               xcvr_en,
    output logic               chain_pass_en,
    output logic               breq_int_en,
    output logic               own_drive,
    output logic               rm_irq,
    output logic               led_blue,
    output logic               led_red,
    output logic               led_green,
    output logic [2:0]         state_dbg
);
    localparam int N_DB = 2;

    logic [N_DB-1:0] raw_vec, clean_vec;
    assign raw_vec = {pwr_good_raw, handle_raw};

    for (genvar i = 0; i < N_DB; i++) begin : g_db
        li_debounce #(.DB_CYCLES(DB_CYCLES)) u_db (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_vec[i]),
            .clean(clean_vec[i])
        );
    end

    li_seq_fsm #(.N_GRANT(N_GRANT)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .handle_ok    (clean_vec[0]),
        .pg_ok        (clean_vec[1]),
        .permit_n     (permit_n),
        .bg_n         (bg_n),
        .iack_n       (iack_n),
        .host_enable  (host_enable),
        .host_poweroff(host_poweroff),
        .host_reset   (host_reset),
        .toggle_off   (toggle_off),
        .wdog_fault   (wdog_fault),
        .pwr_en       (pwr_en),
        .logic_rst    (logic_rst),
        .xcvr_en      (xcvr_en),
        .chain_pass_en(chain_pass_en),
        .breq_int_en  (breq_int_en),
        .own_drive    (own_drive),
        .rm_irq       (rm_irq),
        .led_blue     (led_blue),
        .led_red      (led_red),
        .led_green    (led_green),
        .state_dbg    (state_dbg)
    );
endmodule

// File: tb/li_board_seq_test.sv
`timescale 1ns/1ps
module li_board_seq_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic handle_raw = 0, pwr_good_raw = 0, permit_n = 1;
    logic [3:0] bg_n = 4'hF;
    logic iack_n = 1, host_enable = 0, host_poweroff = 0, host_reset = 0;
    logic toggle_off = 0, wdog_fault = 0;
    logic pwr_en, logic_rst, xcvr_en, chain_pass_en, breq_int_en, own_drive;
    logic rm_irq, led_blue, led_red, led_green;
    logic [2:0] state_dbg;
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    li_board_seq #(.N_GRANT(4), .DB_CYCLES(4)) uut (.*);

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset;
        step(2); rst_n = 1'b1; step(1);
        chk("R1", "state", state_dbg, 0);
        chk("R14", "state code idle", state_dbg, 0);
        chk("R1", "pwr/xcvr/pass/breq/own", {pwr_en, xcvr_en, chain_pass_en, breq_int_en, own_drive}, 0);
        chk("R1", "rst,red,blue,green", {logic_rst, led_red, led_blue, led_green}, 4'b1110);
    endtask

    task automatic t_insert;
        handle_raw = 1; step(10);
        chk("R2", "state", state_dbg, 1);
        step(20);
        chk("R2", "power off while permit high", pwr_en, 0);
        chk("R2", "blue", led_blue, 1);
        permit_n = 0; step(2);
        chk("R3", "state", state_dbg, 2);
        chk("R3", "pwr,rst,pass,breq", {pwr_en, logic_rst, chain_pass_en, breq_int_en}, 4'b1100);
        chk("R3", "red,green", {led_red, led_green}, 2'b11);
        pwr_good_raw = 1; step(10);
        chk("R4", "state", state_dbg, 3);
        chk("R4", "rst,xcvr,pass,breq,own", {logic_rst, xcvr_en, chain_pass_en, breq_int_en, own_drive}, 5'b01000);
        chk("R4", "red,green", {led_red, led_green}, 2'b11);
    endtask

    task automatic t_handover;
        step(5);
        chk("R5", "no handover without host enable", state_dbg, 3);
        bg_n = 4'b1011; host_enable = 1; step(5);
        chk("R5", "held by busy grant", state_dbg, 3);
        chk("R6", "own stays released while grant busy", own_drive, 0);
        bg_n = 4'hF; iack_n = 0; step(5);
        chk("R5", "held by busy acknowledge", state_dbg, 3);
        iack_n = 1; step(2);
        chk("R5", "state run", state_dbg, 4);
        chk("R5", "own,pass,breq", {own_drive, chain_pass_en, breq_int_en}, 3'b111);
        chk("R7", "pass implies own", chain_pass_en & ~own_drive, 0);
        chk("R5", "blue,red,green", {led_blue, led_red, led_green}, 3'b001);
        wdog_fault = 1; step(1);
        chk("R12", "red with watchdog", {led_red, led_green}, 2'b11);
        wdog_fault = 0; step(1);
        handle_raw = 0; step(2); handle_raw = 1; step(10);
        chk("R13", "glitch ignored", state_dbg, 4);
    endtask

    task automatic t_extract_handle;
        bg_n = 4'b1110; handle_raw = 0; step(10);
        chk("R8", "quiesce waits", state_dbg, 5);
        chk("R8", "own,pass kept", {own_drive, chain_pass_en}, 2'b11);
        chk("R9", "irq from handle", rm_irq, 1);
        bg_n = 4'hF; step(1);
        chk("R8", "off bus state", state_dbg, 6);
        chk("R8", "pwr,xcvr,pass,breq,own", {pwr_en, xcvr_en, chain_pass_en, breq_int_en, own_drive}, 5'b10000);
        step(1);
        chk("R8", "power removed", {state_dbg, pwr_en, led_blue}, {3'd0, 1'b0, 1'b1});
        pwr_good_raw = 0; step(10);
    endtask

    task automatic t_host_off;
        handle_raw = 1; step(10);
        pwr_good_raw = 1; step(20);
        chk("R5", "back in run", state_dbg, 4);
        host_poweroff = 1; step(1); host_poweroff = 0; step(3);
        chk("R8", "off bus after host power-off", state_dbg, 6);
        chk("R9", "no irq for host power-off", rm_irq, 0);
        permit_n = 1; step(2);
        chk("R8", "permit high removes power", {state_dbg, pwr_en, led_blue}, {3'd1, 1'b0, 1'b1});
        pwr_good_raw = 0; step(10);
    endtask

    task automatic t_host_reset;
        permit_n = 0; step(3); pwr_good_raw = 1; step(20);
        chk("R5", "run before reset", state_dbg, 4);
        host_reset = 1; step(1); host_reset = 0; step(3);
        chk("R11", "host reset state", state_dbg, 7);
        chk("R11", "pwr,rst,xcvr,pass,own", {pwr_en, logic_rst, xcvr_en, chain_pass_en, own_drive}, 5'b11000);
        chk("R11", "red,green", {led_red, led_green}, 2'b10);
        step(12);
        chk("R11", "latched", state_dbg, 7);
    endtask

    task automatic t_pg_loss;
        pwr_good_raw = 0; step(10);
        chk("R10", "restart waits in power-up", state_dbg, 2);
        pwr_good_raw = 1; step(20);
        chk("R10", "run again", state_dbg, 4);
        pwr_good_raw = 0; step(10);
        chk("R10", "own released after power loss", {own_drive, chain_pass_en}, 0);
        chk("R10", "back at power-up", state_dbg, 2);
    endtask

    task automatic t_toggle;
        pwr_good_raw = 1; step(20);
        toggle_off = 1; step(1); toggle_off = 0; step(3);
        chk("R9", "toggle extraction state", state_dbg, 6);
        chk("R9", "irq from toggle", rm_irq, 1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_insert();
        t_handover();
        t_extract_handle();
        t_host_off();
        t_host_reset();
        t_pg_loss();
        t_toggle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule